// File: doc/BRIEF.md
# Prescaled 8-bit Interval Timer

This block is an 8-bit counter that advances once per prescaler period and raises a sticky interrupt flag each time it rolls over from 255 to 0. The prescaler divides the clock by a power of two picked with a 3-bit select, or it can be bypassed so that the counter steps on every clock. Software reloads the counter through a one-cycle write strobe. That write is also the only event that empties the hidden prescaler stage.

Between reloads the prescaler runs without interruption. Firmware that reloads the counter from an interrupt handler therefore starts a clean prescale period, while firmware that leaves the counter free-running keeps the exact long-term rate. After a reload the counter waits two clock cycles and then begins a complete prescale period. Changing the ratio select does not empty the prescaler: the value it already holds is compared against the new terminal count.

Top module: `tmr_prescaled`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `count` is 0, `irq` is 0 and the prescaler holds 0.
- R2: With `ps_bypass`=1 the counter advances once per clock. With `ps_bypass`=0 it advances once every 2^(`ps_sel`+1) clocks, so `ps_sel`=0 gives 2 and `ps_sel`=7 gives 256.
- R3: A cycle with `wr_en`=1 loads `wr_data` into `count` on the next clock edge and empties the prescaler. The following two clock edges neither advance the counter nor the prescaler. The first increment then lands one full prescale period later, which is edge k+2+N for a write at edge k and a ratio of N.
- R4: Only a counter write empties the prescaler. In all other cases it counts on, and the counter steps at a steady rate for as long as no write occurs.
- R5: A change of `ps_sel` leaves the prescaler value alone. An increment happens on any edge where that value is greater than or equal to the new terminal count, which is 2^(`ps_sel`+1)-1, and the prescaler then returns to 0.
- R6: An increment from 255 sets `irq` on the same edge that `count` becomes 0. A write never sets `irq`, and this includes a write of 0 or 255.
- R7: `irq` stays at 1 until a cycle with `irq_clr`=1 and no rollover, which clears it on the next edge.
- R8: When `irq_clr` and a rollover fall in the same cycle, `irq` ends up at 1.
- R9: A write in a cycle where an increment would otherwise happen takes priority: `count` takes `wr_data`, not the incremented value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Counter write strobe |
| wr_data | input | 8 | Value loaded into the counter |
| ps_sel | input | 3 | Prescale ratio select, divide by 2^(sel+1) |
| ps_bypass | input | 1 | 1: step the counter on every clock |
| irq_clr | input | 1 | Clears the overflow flag |
| count | output | 8 | Current counter value |
| irq | output | 1 | Sticky overflow flag |

## Verification
A behavioural model steps alongside the design on every clock, and the stimulus runs through a series of patterns.

- **Rates.** Runs in bypass and with small and medium ratios confirm the step rate and the select encoding.
- **Reloads.** Reloads in the middle of a period show that a write empties the prescaler and inserts the two-cycle hold-off. Long stretches without writes show that nothing else resets the prescaler.
- **Ratio change.** Switching from a large ratio to a small one while the prescaler holds a high value separates a compare against the new terminal count from a clear-on-change design.
- **Rollover and flag.** Rollovers with `irq_clr` held low, pulsed, and held high across the wrap separate a sticky flag from a pulse and set-priority from clear-priority. A write that lands on an increment cycle shows that the write wins.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Terminal prescaler value for a divide of 2^(sel+1)
  function automatic int unsigned ps_term(input int unsigned sel);
    return (32'd2 << sel) - 32'd1;
  endfunction

  // True when an increment from this value wraps an n-bit counter
  function automatic logic at_top(input logic [31:0] v, input int unsigned n);
    return v == ((32'd1 << n) - 32'd1);
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int SELW = 3,
  parameter int HOLD = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic [SELW-1:0] sel_i,
  input  logic            byp_i,
  output logic            tick_o,
  output logic            hold_o
);
  localparam int PW = 1 << SELW;
  localparam int HW = $clog2(HOLD + 1);

  logic [PW-1:0] pre_q;
  logic [HW-1:0] hold_q;
  logic [PW-1:0] term_w;
  logic          at_term;

  assign term_w  = PW'(tmr_pkg::ps_term(32'(sel_i)));
  assign at_term = pre_q >= term_w;
  assign hold_o  = hold_q != '0;
  assign tick_o  = !clr_i && !hold_o && (byp_i || at_term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      hold_q <= '0;
    end else if (clr_i) begin
      pre_q  <= '0;
      hold_q <= HW'(HOLD);
    end else if (hold_o) begin
      hold_q <= hold_q - HW'(1);
    end else if (byp_i || at_term) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + PW'(1);
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && tmr_pkg::at_top(32'(cnt_q), CW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (tick_i) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/tmr_prescaled.sv
module tmr_prescaled #(
  parameter int CW   = 8,
  parameter int SELW = 3,
  parameter int HOLD = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CW-1:0]   wr_data,
  input  logic [SELW-1:0] ps_sel,
  input  logic            ps_bypass,
  input  logic            irq_clr,
  output logic [CW-1:0]   count,
  output logic            irq
);
  logic tick_w;
  logic wrap_w;
  logic hold_w;

  tmr_prescale #(.SELW(SELW), .HOLD(HOLD)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr_i(wr_en), .sel_i(ps_sel),
    .byp_i(ps_bypass), .tick_o(tick_w), .hold_o(hold_w)
  );

  tmr_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_en), .wdata_i(wr_data),
    .tick_i(tick_w), .cnt_o(count), .wrap_o(wrap_w)
  );

  tmr_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(wrap_w), .clr_i(irq_clr), .flag_o(irq)
  );
endmodule

// File: rtl/tmr_prescaled_chk.sv
module tmr_prescaled_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [CW-1:0] wr_data,
  input logic          irq_clr,
  input logic [CW-1:0] count,
  input logic          irq,
  input logic          tick,
  input logic          wrap,
  input logic          hold
);
  // R3: a write loads the counter on the next edge
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> count == $past(wr_data));
  // R3: no increment in the first of the two hold-off cycles
  a_r3_hold1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tick && hold);
  // R3: nor in the second
  a_r3_hold2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en ##1 !wr_en |=> !tick);
  // R2: an increment adds exactly one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == $past(count) + CW'(1));
  // R4: without a write or an increment the count holds
  a_r4_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && !tick |=> $stable(count));
  // R6: a rollover leaves count at 0 and the flag raised
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> irq && count == '0);
  // R6: only a rollover raises the flag
  a_r6_only_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !irq && !wrap |=> !irq);
  // R7: the flag is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);
  // R7: a clear without a rollover drops the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !wrap |=> !irq);
  // R8: set beats clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && wrap |=> irq);
endmodule

bind tmr_prescaled tmr_prescaled_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .irq_clr(irq_clr), .count(count), .irq(irq),
  .tick(tick_w), .wrap(wrap_w), .hold(hold_w)
);

// File: tb/tmr_prescaled_bench.sv
module tmr_prescaled_bench;
  localparam int CLK_P = 10;
  localparam int WDOG  = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [2:0] ps_sel = 3'd0;
  logic       ps_bypass = 1'b0;
  logic       irq_clr = 1'b0;
  logic [7:0] count;
  logic       irq;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  bit    seen_edge = 1'b0;
  string phase = "R1";

  // reference state
  int m_cnt = 0;
  int m_pre = 0;
  int m_wait = 0;
  int m_irq = 0;

  tmr_prescaled u_tmr_prescaled (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ps_sel(ps_sel), .ps_bypass(ps_bypass), .irq_clr(irq_clr),
    .count(count), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // behavioural model, evaluated on each rising edge
  always @(posedge clk) begin
    bit step;
    int limit;
    cyc++;
    seen_edge = 1'b1;
    step = 1'b0;
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_wait = 0; m_irq = 0;
    end else begin
      limit = (2 << ps_sel) - 1;
      if (wr_en) begin
        m_cnt = wr_data; m_pre = 0; m_wait = 2;
      end else if (m_wait > 0) begin
        m_wait--;
      end else if (ps_bypass) begin
        m_pre = 0; step = 1'b1;
      end else if (m_pre >= limit) begin
        m_pre = 0; step = 1'b1;
      end else begin
        m_pre++;
      end
      if (step) begin
        if (m_cnt == 255) begin
          m_cnt = 0;
          m_irq = 1;
        end else begin
          m_cnt++;
          if (irq_clr) m_irq = 0;
        end
      end else if (irq_clr) begin
        m_irq = 0;
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (seen_edge && !done) begin
      check(phase, "count", int'(count), m_cnt);
      check(phase, "irq", int'(irq), m_irq);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WDOG);
    finish_run();
  end

  initial begin
    // R1: reset state
    phase = "R1";
    idle(3);
    check("R1", "count in reset", int'(count), 0);
    check("R1", "irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    idle(1);
    check("R1", "count after reset", int'(count), 0);
    check("R1", "irq after reset", int'(irq), 0);

    // R2: bypass, then small and medium ratios
    phase = "R2";
    ps_bypass = 1'b1;
    idle(20);
    ps_bypass = 1'b0; ps_sel = 3'd0;
    idle(20);
    ps_sel = 3'd2;
    idle(40);

    // R3: reload mid period, then again
    phase = "R3";
    ps_sel = 3'd3;
    idle(5);
    wr(100);
    idle(40);
    idle(7);
    wr(30);
    idle(3);
    check("R3", "count still held after reload", int'(count), 30);
    idle(30);

    // R4: long free run, prescaler never reset
    phase = "R4";
    ps_sel = 3'd1;
    idle(100);
    ps_sel = 3'd0;
    idle(37);

    // R5: ratio change keeps the prescaler value
    phase = "R5";
    ps_sel = 3'd4;
    wr(10);
    idle(27);
    ps_sel = 3'd1;
    idle(20);
    ps_sel = 3'd5;
    idle(70);

    // R6: rollover, and writes of 0 and 255 never raise the flag
    phase = "R6";
    ps_bypass = 1'b1;
    wr(255);
    idle(1);
    check("R6", "write 255 leaves irq low", int'(irq), 0);
    wr(0);
    idle(1);
    check("R6", "write 0 leaves irq low", int'(irq), 0);
    wr(250);
    idle(12);
    check("R6", "irq after rollover", int'(irq), 1);

    // R7: sticky, then a clear pulse
    phase = "R7";
    ps_bypass = 1'b0; ps_sel = 3'd7;
    idle(10);
    check("R7", "irq still set", int'(irq), 1);
    irq_clr = 1'b1;
    idle(1);
    irq_clr = 1'b0;
    idle(1);
    check("R7", "irq after clear", int'(irq), 0);

    // R8: clear held across a rollover
    phase = "R8";
    ps_bypass = 1'b1;
    wr(253);
    irq_clr = 1'b1;
    idle(10);
    irq_clr = 1'b0;
    wr(254);
    idle(3);
    irq_clr = 1'b1;
    idle(1);
    irq_clr = 1'b0;
    idle(4);

    // R9: write lands on an increment cycle
    phase = "R9";
    wr(40);
    idle(6);
    wr(200);
    check("R9", "write wins over increment", int'(count), 200);
    idle(10);
    ps_bypass = 1'b0; ps_sel = 3'd0;
    idle(5);
    wr(77);
    idle(10);

    finish_run();
  end
endmodule